// File: doc/BRIEF.md
# Nibble Replacement Run-Length Encoder

This block turns one block of user bits into a slightly longer channel word whose zero runs are bounded. The word is split into q-bit nibbles. A leading marker bit, set to 1, is placed in front of the first q-1 user bits to form the head nibble. In a first pass every all-zero nibble after the head is removed. Its slot is filled with the current head contents, and the head is turned into a pointer (marker 0, low bits = slot position). The result is a linked chain that a decoder can unwind. In a second pass, left to right, any all-ones nibble that follows a nibble ending in 1 is inverted. The decoder can spot it uniquely, because after the first pass no all-zero nibble is left.

With the default q = 4 there are L = 2^(q-1) = 8 nibbles, 31 input bits and 32 output bits. Blocks enter and leave through valid/ready handshakes. A single output register holds the one block in flight. The encoding is computed in the cycle a block is accepted and is presented on the next cycle.

Top module: `nre_encoder`

## Requirements
- R1: With nibble width q, the block takes q*2^(q-1)-1 input bits and gives q*2^(q-1) output bits. Output nibble j (1-based) is out_data[n-1-(j-1)q -: q], and its last bit is the LSB. Input bits [n-2 -: q-1] form the head's user bits and the remaining q-bit groups are nibbles 2..L in order.
- R2: If none of the input nibbles 2..L is all zeros, out_data MSB (marker) is 1 and the low q-1 bits of nibble 1 equal the input's head bits. All other nibbles are unchanged except for R4 inversions.
- R3: Nibbles 2..L are visited in ascending order. An all-zero nibble at position p takes the current head contents, and the head becomes {0, p-1}. When every input nibble is zero, the default output is 0x78123456.
- R4: After replacement, nibble j (j ≥ 2) is inverted exactly when it is all ones and the already-processed nibble j-1 ends in 1.
- R5: Nibble 1 is never inverted and is never all zeros.
- R6: An all-zero output nibble is always preceded by a nibble ending in 1, and no output zero run exceeds 2q-1 bits.
- R7: Undoing the inversions (all-zero → all-ones) and then unwinding the pointer chain from the head returns the original input.
- R8: in_ready is high when the output slot is empty or is being drained that cycle. An accepted block appears with out_valid on the next cycle. out_data is held stable while out_valid is high and out_ready is low.
- R9: During and after synchronous active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Encoder can take a block |
| in_data | input | n-1 (31) | User bits, head bits at the top |
| out_valid | output | 1 | Encoded word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | n (32) | Encoded word, nibble 1 at the top |

## Verification
The hardest case to reach is an interaction between the two passes. A replaced slot receives the original head, and that head is all ones when the head user bits are all ones. The inversion pass must then flip that relocated nibble, because the pointer in front of it ends in 1. Only a decoder that reverses the inversion before unwinding the chain recovers the data. A directed case builds exactly this input. Other directed inputs produce chains of every length (up to all-zero input), inversion runs that alternate, and inversion that is blocked by an already-inverted neighbour. A biased random stream, in which each nibble is zero half of the time, is decoded by a reference model in the bench and is scanned for zero runs.

// File: rtl/nre_pkg.sv
// Package: shared sizing helpers for the nibble replacement encoder.
// Assumes nibble width of at least 2 bits.
package nre_pkg;
    localparam int unsigned NRE_NIB_W_DEFAULT = 4;

    // Number of nibbles per word for a given nibble width.
    function automatic int unsigned nre_nib_count(input int unsigned nib_w);
        return 32'd1 << (nib_w - 1);
    endfunction
endpackage

// File: rtl/nre_replace.sv
// Module: nre_replace
// Removes all-zero nibbles (positions 2..L) by moving the current head
// nibble into the vacated slot and turning the head into a pointer.
// Assumes raw_word already carries the marker bit (1) at its MSB.
// Purely combinational; a ripple chain of NIBS-1 stages.
module nre_replace #(
    parameter int unsigned NIB_W = 4,
    parameter int unsigned NIBS  = 8
) (
    input  logic [NIB_W*NIBS-1:0] raw_word,
    output logic [NIB_W*NIBS-1:0] repl_word
);
    localparam int unsigned WORD_W = NIB_W * NIBS;
    localparam int unsigned PTR_W  = NIB_W - 1;

    logic [NIB_W-1:0] head [NIBS];

    assign head[0] = raw_word[WORD_W-1 -: NIB_W];

    generate
        for (genvar i = 1; i < NIBS; i++) begin : g_stage
            logic [NIB_W-1:0] nib;
            logic             is_zero;
            assign nib     = raw_word[WORD_W-1-i*NIB_W -: NIB_W];
            assign is_zero = (nib == '0);
            // Slot takes old head when zero; head becomes pointer to slot.
            assign repl_word[WORD_W-1-i*NIB_W -: NIB_W] = is_zero ? head[i-1] : nib;
            assign head[i] = is_zero ? {1'b0, PTR_W'(i)} : head[i-1];
        end
    endgenerate

    assign repl_word[WORD_W-1 -: NIB_W] = head[NIBS-1];
endmodule

// File: rtl/nre_flip.sv
// Module: nre_flip
// Inverts every all-ones nibble whose left neighbour (after its own
// inversion decision) ends in 1. The first nibble sees a virtual 0.
// Purely combinational; left-to-right ripple over NIBS nibbles.
module nre_flip #(
    parameter int unsigned NIB_W = 4,
    parameter int unsigned NIBS  = 8
) (
    input  logic [NIB_W*NIBS-1:0] repl_word,
    output logic [NIB_W*NIBS-1:0] flip_word
);
    localparam int unsigned WORD_W = NIB_W * NIBS;

    logic prev_last [NIBS+1];

    assign prev_last[0] = 1'b0;

    generate
        for (genvar i = 0; i < NIBS; i++) begin : g_stage
            logic [NIB_W-1:0] nib;
            logic [NIB_W-1:0] res;
            assign nib = repl_word[WORD_W-1-i*NIB_W -: NIB_W];
            // Invert all-ones nibble that would extend a trailing 1.
            assign res = ((nib == '1) && prev_last[i]) ? ~nib : nib;
            assign flip_word[WORD_W-1-i*NIB_W -: NIB_W] = res;
            assign prev_last[i+1] = res[0];
        end
    endgenerate
endmodule

// File: rtl/nre_encoder.sv
// Module: nre_encoder (top)
// Accepts one block of n-1 user bits per handshake, prepends the marker
// bit, runs replacement then inversion, and holds the n-bit result in a
// single output register until the consumer takes it.
// Assumes: synchronous active-low reset; in_data stable while offered.
module nre_encoder #(
    parameter int unsigned NIB_W  = nre_pkg::NRE_NIB_W_DEFAULT,
    localparam int unsigned NIBS   = nre_pkg::nre_nib_count(NIB_W),
    localparam int unsigned WORD_W = NIB_W * NIBS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-2:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    logic [WORD_W-1:0] raw_word;
    logic [WORD_W-1:0] repl_word;
    logic [WORD_W-1:0] enc_word;
    logic              take;

    assign raw_word = {1'b1, in_data};

    nre_replace #(.NIB_W(NIB_W), .NIBS(NIBS)) u_replace (
        .raw_word (raw_word),
        .repl_word(repl_word)
    );

    nre_flip #(.NIB_W(NIB_W), .NIBS(NIBS)) u_flip (
        .repl_word(repl_word),
        .flip_word(enc_word)
    );

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    // Output slot: load on accept, clear on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= enc_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Reset leaves the slot empty.
    assert_reset_empty_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // Held word does not change under back-pressure.
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // Head nibble is never zero (never inverted, never empty).
    assert_head_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[WORD_W-1 -: NIB_W] != '0);

    generate
        for (genvar j = 1; j < NIBS; j++) begin : g_chk
            // A zero nibble only appears right after a nibble ending in 1.
            assert_zero_after_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && out_data[WORD_W-1-j*NIB_W -: NIB_W] == '0
                |-> out_data[WORD_W-j*NIB_W]);
            // An all-ones nibble never survives after a nibble ending in 1.
            assert_ones_after_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && out_data[WORD_W-1-j*NIB_W -: NIB_W] == '1
                |-> !out_data[WORD_W-j*NIB_W]);
        end
    endgenerate
endmodule

// File: tb/nre_encoder_test.sv
module nre_encoder_test;
    localparam int Q  = 4;
    localparam int NL = 8;
    localparam int W  = Q * NL;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-2:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;

    nre_encoder #(.NIB_W(Q)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference decoder: undo inversions, then unwind pointer chain.
    function automatic logic [W-2:0] ref_decode(input logic [W-1:0] c);
        logic [Q-1:0] n [NL];
        logic [Q-1:0] hd;
        int p;
        for (int i = 0; i < NL; i++) begin
            n[i] = c[W-1-i*Q -: Q];
            if (n[i] == '0) n[i] = '1;
        end
        for (int g = 0; g < NL && n[0][Q-1] == 1'b0; g++) begin
            p = int'(n[0][Q-2:0]);
            hd = n[p];
            n[p] = '0;
            n[0] = hd;
        end
        for (int i = 0; i < NL; i++) c[W-1-i*Q -: Q] = n[i];
        return c[W-2:0];
    endfunction

    function automatic int max_zero_run(input logic [W-1:0] c);
        int run = 0, best = 0;
        for (int i = W-1; i >= 0; i--) begin
            run  = c[i] ? 0 : run + 1;
            best = (run > best) ? run : best;
        end
        return best;
    endfunction

    // Offer one block, check next-cycle validity (R8), drain it.
    task automatic encode(input logic [W-2:0] d, output logic [W-1:0] o);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 valid next cycle", W'(out_valid), W'(1));
        o = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 out_valid in reset", W'(out_valid), W'(0));
        check("R9 in_ready in reset", W'(in_ready), W'(1));
    endtask

    task automatic t_all_zero();
        logic [W-1:0] o;
        encode('0, o);
        check("R3 all-zero chain", o, 32'h7812_3456);
        check("R7 all-zero round trip", W'(ref_decode(o)), W'(0));
    endtask

    task automatic t_all_ones();
        logic [W-1:0] o;
        encode('1, o);
        check("R4 alternating inversion", o, 32'hF0F0_F0F0);
    endtask

    task automatic t_no_zero();
        logic [W-1:0] o;
        encode({3'b010, 4'h2, 4'h4, 4'h6, 4'h9, 4'hB, 4'hC, 4'hE}, o);
        check("R2 marker kept, pass-through", o, 32'hA246_9BCE);
    endtask

    task automatic t_single_zero();
        logic [W-1:0] o;
        encode({3'b101, 4'h5, 4'h5, 4'h5, 4'h0, 4'h5, 4'h5, 4'h5}, o);
        check("R3 single slot at position 5", o, 32'h4555_D555);
    endtask

    task automatic t_flip_chain();
        logic [W-1:0] o;
        encode({3'b111, 4'hF, 4'h3, 4'hF, 4'h1, 4'hF, 4'hF, 4'h8}, o);
        check("R4 R5 inversion uses processed neighbour", o, 32'hF030_10F8);
    endtask

    task automatic t_relocated_flip();
        logic [W-1:0] o;
        logic [W-2:0] d;
        d = {3'b111, 4'h0, 4'h6, 4'h6, 4'h6, 4'h6, 4'h6, 4'h6};
        encode(d, o);
        check("R4 relocated head inverted", o, 32'h1066_6666);
        check("R7 relocated head round trip", W'(ref_decode(o)), W'(d));
    endtask

    task automatic t_backpressure();
        logic [W-1:0] first;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {3'b001, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7};
        @(negedge clk);
        in_data  = {3'b011, 4'h0, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7};
        first = out_data;
        check("R8 first word", first, 32'h9123_4567);
        repeat (3) begin
            @(negedge clk);
            check("R8 held under back-pressure", out_data, first);
            check("R8 in_ready low when full", W'(in_ready), W'(0));
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check("R8 drain and refill same edge", W'(out_valid), W'(1));
        check("R8 second word", out_data, 32'h1B23_4567);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R8 slot empties", W'(out_valid), W'(0));
    endtask

    task automatic t_random();
        logic [W-1:0] o;
        logic [W-2:0] d;
        for (int b = 0; b < 300; b++) begin
            d = W'($urandom);
            for (int i = 0; i < NL-1; i++)
                if ($urandom_range(1, 0) == 1) d[i*Q +: Q] = '0;
            if ($urandom_range(3, 0) == 0) d[W-2 -: Q-1] = '1;
            encode(d, o);
            check("R7 random round trip", W'(ref_decode(o)), W'(d));
            check("R6 zero run limit", W'(max_zero_run(o) <= 2*Q-1), W'(1));
            check("R1 R5 head nonzero", W'(o[W-1 -: Q] != '0), W'(1));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_zero();
        t_all_ones();
        t_no_zero();
        t_single_zero();
        t_flip_chain();
        t_relocated_flip();
        t_backpressure();
        t_random();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule